// File: doc/BRIEF.md
# Serial Flash Read and Identify Engine

This block is the device-side logic of a serial NOR flash slave that serves read-type commands only. A host selects the device by pulling chip select low, shifts in an 8-bit opcode and, for memory reads, a 24-bit address. The block then streams bytes from a 2M x 8 array. The array sits behind a simple synchronous read port: data is returned the cycle after a request. Four commands are served: a plain read, a fast read with one dummy byte, a dual-output fast read that drives two data pins per serial clock, and an identification read that returns a fixed signature followed by a unique-ID block.

The serial clock, chip select and the serial data input are synchronised into a faster system clock, and both edges of the serial clock are detected there. Input bits are taken on serial-clock rising edges and output bits change on falling edges, so both clock polarities where data is captured on the rising edge are served (idle-low and idle-high). A busy input from the write/erase side makes the block refuse any command that completes while a write cycle is running.

Top module: `flash_read_engine`

## Requirements
- R1: After reset both data outputs are high impedance (`spi_dq1_oe` and `spi_dq0_oe` low) and `mem_rd` is low.
- R2: Opcode, address and dummy bits are taken MSB first on rising serial-clock edges and output bits change only after falling edges, for serial clock idle-low or idle-high; each serial-clock phase lasts at least 6 system clocks.
- R3: Opcode 03h followed by a 24-bit address (MSB first) returns, with no dummy byte, the array byte at that address on DQ1, MSB first, starting at the first falling edge after the last address bit.
- R4: The read address increments by one after every byte; after 1FFFFFh it wraps to 000000h and streaming continues; address bits 23 to 21 are ignored.
- R5: Opcode 0Bh behaves as 03h but one dummy byte follows the address before the first data bit.
- R6: Opcode 3Bh takes one dummy byte after the address and then drives two bits per serial clock: DQ1 carries bits 7, 5, 3, 1 and DQ0 carries bits 6, 4, 2, 0 of each byte; DQ0 is driven only in this command's data phase.
- R7: Opcode 9Fh returns 20h, 71h, 15h, then a length byte 10h, then the 16 unique-ID bytes most significant byte first; every byte after those is 00h.
- R8: A command whose opcode completes while `busy_i` is high is ignored: both outputs stay high impedance until deselect.
- R9: Any opcode other than 03h, 0Bh, 3Bh and 9Fh is ignored: both outputs stay high impedance until deselect.
- R10: Raising chip select aborts the command at any bit: both outputs become high impedance within 4 system clocks, and the next selection starts with a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_dq0_in | input | 1 | Serial data in (DQ0 input side) |
| busy_i | input | 1 | Write/erase cycle in progress |
| mem_rd | output | 1 | Array read request, one cycle |
| mem_addr | output | 21 | Array read address |
| mem_rdata | input | 8 | Array data, valid the cycle after `mem_rd` |
| spi_dq0_out | output | 1 | DQ0 output data (dual mode) |
| spi_dq0_oe | output | 1 | DQ0 output enable |
| spi_dq1_out | output | 1 | DQ1 output data |
| spi_dq1_oe | output | 1 | DQ1 output enable |

## Verification
The bench aims at the top-of-array wrap, where a design that kept 24 address bits or saturated would return bytes from beyond the array or repeat the last byte, and at high address bits that must be dropped. It checks the dual-output bit split, which a swapped pin order would scramble, and the dummy byte count of both fast reads, where an off-by-one shifts every byte by eight bits. It also checks the end of the identification stream, the refusal of busy and unknown commands (a design that ignored them would drive the bus), and deselect in the middle of a byte, after which a design that kept its bit counter would misread the next opcode.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_FAST  = 8'h0B;
   localparam logic [7:0] OPC_DUAL  = 8'h3B;
   localparam logic [7:0] OPC_IDENT = 8'h9F;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_DROP
   } fe_state_e;

   typedef enum logic [1:0] {
      RD_SLOW,
      RD_FAST,
      RD_DUAL,
      RD_IDENT
   } rd_kind_e;

   typedef struct packed {
      logic     ok;
      rd_kind_e kind;
   } opc_dec_t;

   function automatic opc_dec_t decode_opc(input logic [7:0] op);
      opc_dec_t d;
      d.ok   = 1'b1;
      d.kind = RD_SLOW;
      unique case (op)
         OPC_READ:  d.kind = RD_SLOW;
         OPC_FAST:  d.kind = RD_FAST;
         OPC_DUAL:  d.kind = RD_DUAL;
         OPC_IDENT: d.kind = RD_IDENT;
         default:   d.ok   = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic dq_i,
   output logic sel_o,
   output logic rise_o,
   output logic fall_o,
   output logic dq_o
);

   localparam int MSB = STAGES - 1;

   logic [MSB:0] sck_p;
   logic [MSB:0] cs_p;
   logic [MSB:0] dq_p;
   logic         sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p <= '0;
         cs_p  <= '1;
         dq_p  <= '0;
         sck_d <= 1'b0;
      end else begin
         sck_p <= {sck_p[MSB-1:0], sck_i};
         cs_p  <= {cs_p[MSB-1:0], cs_n_i};
         dq_p  <= {dq_p[MSB-1:0], dq_i};
         sck_d <= sck_p[MSB];
      end
   end

   assign sel_o  = ~cs_p[MSB];
   assign rise_o = sck_p[MSB] & ~sck_d;
   assign fall_o = ~sck_p[MSB] & sck_d;
   assign dq_o   = dq_p[MSB];

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
   import flash_rd_pkg::*;
#(
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              rise_i,
   input  logic              dq_i,
   input  logic              busy_i,
   output rd_kind_e          kind_o,
   output logic              in_data_o,
   output logic              addr_load_o,
   output logic [ADDR_W-1:0] addr_val_o,
   output logic              start_o
);

   localparam int CMD_ADDR_BITS = 24;

   fe_state_e   state;
   logic [4:0]  cnt;
   logic [CMD_ADDR_BITS-2:0] sh;
   logic [CMD_ADDR_BITS-1:0] word_now;
   opc_dec_t    dec;

   assign word_now = {sh, dq_i};
   assign dec      = decode_opc(word_now[7:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_OPC;
         cnt         <= '0;
         sh          <= '0;
         kind_o      <= RD_SLOW;
         addr_load_o <= 1'b0;
         addr_val_o  <= '0;
         start_o     <= 1'b0;
      end else begin
         addr_load_o <= 1'b0;
         start_o     <= 1'b0;
         if (!sel_i) begin
            state <= ST_OPC;
            cnt   <= '0;
         end else if (rise_i) begin
            sh <= word_now[CMD_ADDR_BITS-2:0];
            unique case (state)
               ST_OPC: begin
                  if (cnt == 5'd7) begin
                     cnt <= '0;
                     if (!dec.ok || busy_i) begin
                        state <= ST_DROP;
                     end else begin
                        kind_o <= dec.kind;
                        if (dec.kind == RD_IDENT) begin
                           state   <= ST_DATA;
                           start_o <= 1'b1;
                        end else begin
                           state <= ST_ADDR;
                        end
                     end
                  end else begin
                     cnt <= cnt + 5'd1;
                  end
               end
               ST_ADDR: begin
                  if (cnt == 5'd23) begin
                     cnt         <= '0;
                     addr_load_o <= 1'b1;
                     addr_val_o  <= word_now[ADDR_W-1:0];
                     if (kind_o == RD_SLOW) begin
                        state   <= ST_DATA;
                        start_o <= 1'b1;
                     end else begin
                        state <= ST_DUMMY;
                     end
                  end else begin
                     cnt <= cnt + 5'd1;
                  end
               end
               ST_DUMMY: begin
                  if (cnt == 5'd7) begin
                     cnt     <= '0;
                     state   <= ST_DATA;
                     start_o <= 1'b1;
                  end else begin
                     cnt <= cnt + 5'd1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign in_data_o = (state == ST_DATA);

   // R8
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && rise_i && state == ST_OPC && cnt == 5'd7 && busy_i) |=> (state == ST_DROP));

   // R9
   bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && rise_i && state == ST_OPC && cnt == 5'd7 && !dec.ok) |=> (state == ST_DROP));

endmodule

// File: rtl/flash_byte_src.sv
module flash_byte_src
   import flash_rd_pkg::*;
#(
   parameter int                     ADDR_W    = 21,
   parameter int                     UID_BYTES = 16,
   parameter logic [UID_BYTES*8-1:0] UID_VALUE = '0,
   parameter logic [7:0]             ID_MFR    = 8'h20,
   parameter logic [7:0]             ID_TYPE   = 8'h71,
   parameter logic [7:0]             ID_CAP    = 8'h15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  rd_kind_e          kind_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_val_i,
   input  logic              start_i,
   input  logic              next_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [7:0]        mem_rdata_i,
   output logic [7:0]        byte_o,
   output logic              valid_o
);

   localparam int                ID_TOTAL = UID_BYTES + 4;
   localparam int                IDX_W    = $clog2(ID_TOTAL + 1);
   localparam logic [IDX_W-1:0]  IDX_END  = IDX_W'(ID_TOTAL);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  idx;
   logic              start_q;
   logic              pend;
   logic              fetch;
   logic              ident;

   function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] i);
      if (i == IDX_W'(0))      return ID_MFR;
      else if (i == IDX_W'(1)) return ID_TYPE;
      else if (i == IDX_W'(2)) return ID_CAP;
      else if (i == IDX_W'(3)) return 8'(UID_BYTES);
      else if (i < IDX_END)    return UID_VALUE[(ID_TOTAL - 1 - int'(i)) * 8 +: 8];
      else                     return 8'h00;
   endfunction

   assign ident      = (kind_i == RD_IDENT);
   assign fetch      = sel_i & (start_q | next_i);
   assign mem_rd_o   = fetch & ~ident;
   assign mem_addr_o = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         idx     <= '0;
         start_q <= 1'b0;
         pend    <= 1'b0;
         byte_o  <= '0;
         valid_o <= 1'b0;
      end else if (!sel_i) begin
         idx     <= '0;
         start_q <= 1'b0;
         pend    <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         start_q <= start_i;
         if (addr_load_i) begin
            addr_q <= addr_val_i;
         end else if (mem_rd_o) begin
            addr_q <= addr_q + ADDR_ONE;
         end
         if (fetch && ident) begin
            byte_o  <= id_byte(idx);
            valid_o <= 1'b1;
            if (idx != IDX_END) idx <= idx + IDX_W'(1);
         end else if (fetch) begin
            pend    <= 1'b1;
            valid_o <= 1'b0;
         end else if (pend) begin
            pend    <= 1'b0;
            byte_o  <= mem_rdata_i;
            valid_o <= 1'b1;
         end
      end
   end

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && !addr_load_i) |=> (addr_q == $past(addr_q) + ADDR_ONE));

   // R7
   ident_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && kind_i == RD_IDENT) |-> !mem_rd_o);

endmodule

// File: rtl/flash_out_shift.sv
module flash_out_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_i,
   input  logic       active_i,
   input  logic       dual_i,
   input  logic       fall_i,
   input  logic [7:0] byte_i,
   input  logic       valid_i,
   output logic       next_o,
   output logic       dq1_o,
   output logic       dq1_oe_o,
   output logic       dq0_o,
   output logic       dq0_oe_o
);

   logic [2:0] cnt;
   logic [7:0] sh;
   logic [2:0] last;
   logic       load;

   assign last = dual_i ? 3'd3 : 3'd7;
   assign load = sel_i & active_i & fall_i & (cnt == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sh       <= '0;
         next_o   <= 1'b0;
         dq1_o    <= 1'b0;
         dq0_o    <= 1'b0;
         dq1_oe_o <= 1'b0;
         dq0_oe_o <= 1'b0;
      end else begin
         next_o <= 1'b0;
         if (!sel_i || !active_i) begin
            cnt      <= '0;
            dq1_oe_o <= 1'b0;
            dq0_oe_o <= 1'b0;
         end else if (fall_i) begin
            dq1_oe_o <= 1'b1;
            dq0_oe_o <= dual_i;
            cnt      <= (cnt == last) ? 3'd0 : cnt + 3'd1;
            if (load) begin
               dq1_o  <= byte_i[7];
               dq0_o  <= byte_i[6];
               sh     <= dual_i ? {byte_i[5:0], 2'b00} : {byte_i[6:0], 1'b0};
               next_o <= 1'b1;
            end else begin
               dq1_o <= sh[7];
               dq0_o <= sh[6];
               sh    <= dual_i ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
            end
         end
      end
   end

   // R6
   dq0_dual_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq0_oe_o |-> dual_i);

   // R2
   byte_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> valid_i);

endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
   import flash_rd_pkg::*;
#(
   parameter int                     ADDR_W      = 21,
   parameter int                     SYNC_STAGES = 2,
   parameter int                     UID_BYTES   = 16,
   parameter logic [UID_BYTES*8-1:0] UID_VALUE   = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
   parameter logic [7:0]             ID_MFR      = 8'h20,
   parameter logic [7:0]             ID_TYPE     = 8'h71,
   parameter logic [7:0]             ID_CAP      = 8'h15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_dq0_in,
   input  logic              busy_i,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              spi_dq0_out,
   output logic              spi_dq0_oe,
   output logic              spi_dq1_out,
   output logic              spi_dq1_oe
);

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("ADDR_W must lie in 1..24");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (UID_BYTES < 1 || UID_BYTES > 255) begin : g_bad_uid
      $error("UID_BYTES must lie in 1..255");
   end

   logic              sel;
   logic              rise;
   logic              fall;
   logic              dq_s;
   rd_kind_e          kind;
   logic              in_data;
   logic              addr_load;
   logic [ADDR_W-1:0] addr_val;
   logic              start;
   logic              next_req;
   logic [7:0]        cur_byte;
   logic              cur_valid;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_i  (spi_sck),
      .cs_n_i (spi_cs_n),
      .dq_i   (spi_dq0_in),
      .sel_o  (sel),
      .rise_o (rise),
      .fall_o (fall),
      .dq_o   (dq_s)
   );

   flash_cmd_front #(.ADDR_W(ADDR_W)) i_front (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel),
      .rise_i      (rise),
      .dq_i        (dq_s),
      .busy_i      (busy_i),
      .kind_o      (kind),
      .in_data_o   (in_data),
      .addr_load_o (addr_load),
      .addr_val_o  (addr_val),
      .start_o     (start)
   );

   flash_byte_src #(
      .ADDR_W    (ADDR_W),
      .UID_BYTES (UID_BYTES),
      .UID_VALUE (UID_VALUE),
      .ID_MFR    (ID_MFR),
      .ID_TYPE   (ID_TYPE),
      .ID_CAP    (ID_CAP)
   ) i_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel),
      .kind_i      (kind),
      .addr_load_i (addr_load),
      .addr_val_i  (addr_val),
      .start_i     (start),
      .next_i      (next_req),
      .mem_rd_o    (mem_rd),
      .mem_addr_o  (mem_addr),
      .mem_rdata_i (mem_rdata),
      .byte_o      (cur_byte),
      .valid_o     (cur_valid)
   );

   flash_out_shift i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (sel),
      .active_i (in_data),
      .dual_i   (kind == RD_DUAL),
      .fall_i   (fall),
      .byte_i   (cur_byte),
      .valid_i  (cur_valid),
      .next_o   (next_req),
      .dq1_o    (spi_dq1_out),
      .dq1_oe_o (spi_dq1_oe),
      .dq0_o    (spi_dq0_out),
      .dq0_oe_o (spi_dq0_oe)
   );

   // R10
   deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (!spi_dq1_oe && !spi_dq0_oe));

   // R3
   mem_rd_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (sel && in_data));

endmodule

// File: tb/test_flash_read_engine.sv
module test_flash_read_engine;

   localparam int HALF = 6;
   localparam logic [127:0] UID = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        busy = 1'b0;
   logic        mem_rd;
   logic [20:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h00;
   logic        dq0_out, dq0_oe, dq1_out, dq1_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit mode3  = 1'b0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   flash_read_engine i_flash_read_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sck     (sck),
      .spi_cs_n    (cs_n),
      .spi_dq0_in  (mosi),
      .busy_i      (busy),
      .mem_rd      (mem_rd),
      .mem_addr    (mem_addr),
      .mem_rdata   (mem_rdata),
      .spi_dq0_out (dq0_out),
      .spi_dq0_oe  (dq0_oe),
      .spi_dq1_out (dq1_out),
      .spi_dq1_oe  (dq1_oe)
   );

   function automatic logic [7:0] mem_val(input logic [20:0] a);
      return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'hA5;
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= mem_val(mem_addr);

   function automatic logic [7:0] id_exp(input int i);
      if (i == 0) return 8'h20;
      if (i == 1) return 8'h71;
      if (i == 2) return 8'h15;
      if (i == 3) return 8'h10;
      if (i < 20) return UID[(19 - i) * 8 +: 8];
      return 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic begin_sel();
      sck = mode3;
      clks(4);
      cs_n = 1'b0;
      clks(HALF);
   endtask

   task automatic end_sel();
      if (!mode3) begin
         sck = 1'b0;
         clks(HALF);
      end
      cs_n = 1'b1;
      clks(8);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sck  = 1'b0;
         mosi = b[i];
         clks(HALF);
         sck = 1'b1;
         clks(HALF);
      end
   endtask

   task automatic read_byte(input bit dual, output logic [7:0] b, output logic [1:0] oe, output bit any_oe);
      b = '0;
      any_oe = 1'b0;
      oe = '0;
      for (int k = 0; k < (dual ? 4 : 8); k++) begin
         sck = 1'b0;
         clks(HALF);
         if (dual) b = {b[5:0], dq1_out, dq0_out};
         else      b = {b[6:0], dq1_out};
         oe = {dq1_oe, dq0_oe};
         any_oe = any_oe | dq1_oe | dq0_oe;
         sck = 1'b1;
         clks(HALF);
      end
   endtask

   task automatic do_read(input logic [7:0] opc, input logic [23:0] addr, input int n, input string tag);
      logic [7:0]  b;
      logic [1:0]  oe;
      bit          any;
      bit          dual;
      logic [20:0] a;
      dual = (opc == 8'h3B);
      begin_sel();
      send_byte(opc);
      send_byte(addr[23:16]);
      send_byte(addr[15:8]);
      send_byte(addr[7:0]);
      if (opc != 8'h03) send_byte(8'h00);
      for (int i = 0; i < n; i++) begin
         a = addr[20:0] + 21'(i);
         read_byte(dual, b, oe, any);
         chk(tag, {24'h0, b}, {24'h0, mem_val(a)});
         chk({tag, " R6 pin enables"}, {30'h0, oe}, {30'h0, 1'b1, dual});
      end
      end_sel();
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      logic [7:0] b;
      logic [1:0] oe;
      bit any;
      void'($urandom(32'd20240611));
      clks(3);
      // R1 reset state
      chk("R1 oe after reset", {30'h0, dq1_oe, dq0_oe}, 32'h0);
      chk("R1 mem_rd after reset", {31'h0, mem_rd}, 32'h0);
      rst_n = 1'b1;
      clks(4);
      chk("R1 oe idle", {30'h0, dq1_oe, dq0_oe}, 32'h0);

      // R3 plain read, idle-low clock (R2)
      mode3 = 1'b0;
      do_read(8'h03, 24'h012345, 3, "R3 read mode0");
      // R2 idle-high clock
      mode3 = 1'b1;
      do_read(8'h03, 24'h0ABCDE, 2, "R2 read mode3");
      // R4 wrap at top of array
      mode3 = 1'b0;
      do_read(8'h03, 24'h1FFFFE, 4, "R4 wrap");
      // R4 upper address bits ignored
      do_read(8'h03, 24'hE00005, 2, "R4 high bits");
      // R5 fast read with dummy byte
      do_read(8'h0B, 24'h1FFFFF, 3, "R5 fast wrap");
      // R6 dual output
      mode3 = 1'b1;
      do_read(8'h3B, 24'h00F0F0, 3, "R6 dual");
      mode3 = 1'b0;
      do_read(8'h3B, 24'h1FFFFF, 2, "R6 dual wrap");

      // R7 identification, including tail of zeros
      begin_sel();
      send_byte(8'h9F);
      for (int i = 0; i < 22; i++) begin
         read_byte(1'b0, b, oe, any);
         chk($sformatf("R7 ident byte %0d", i), {24'h0, b}, {24'h0, id_exp(i)});
      end
      chk("R7 ident dq0 off", {31'h0, oe[0]}, 32'h0);
      end_sel();

      // R8 busy refuses the command
      busy = 1'b1;
      begin_sel();
      send_byte(8'h03);
      send_byte(8'h00); send_byte(8'h00); send_byte(8'h10);
      read_byte(1'b0, b, oe, any);
      chk("R8 busy no drive", {31'h0, any}, 32'h0);
      read_byte(1'b0, b, oe, any);
      chk("R8 busy no drive 2", {31'h0, any}, 32'h0);
      end_sel();
      busy = 1'b0;
      do_read(8'h03, 24'h000010, 1, "R8 after busy");

      // R9 unknown opcode
      begin_sel();
      send_byte(8'h5A);
      for (int i = 0; i < 3; i++) begin
         read_byte(1'b1, b, oe, any);
         chk("R9 unknown no drive", {31'h0, any}, 32'h0);
      end
      end_sel();

      // R10 abort mid-byte during data
      begin_sel();
      send_byte(8'h0B);
      send_byte(8'h12); send_byte(8'h34); send_byte(8'h56); send_byte(8'h00);
      for (int k = 0; k < 3; k++) begin
         sck = 1'b0; clks(HALF); sck = 1'b1; clks(HALF);
      end
      chk("R10 driving before abort", {31'h0, dq1_oe}, 32'h1);
      cs_n = 1'b1;
      clks(4);
      chk("R10 hiz after abort", {30'h0, dq1_oe, dq0_oe}, 32'h0);
      clks(6);
      // R10 abort mid-address, then fresh command
      begin_sel();
      send_byte(8'h03);
      send_byte(8'h07);
      for (int k = 0; k < 5; k++) begin
         sck = 1'b0; clks(HALF); sck = 1'b1; clks(HALF);
      end
      end_sel();
      do_read(8'h03, 24'h054321, 2, "R10 fresh command");

      // Random mix of read commands
      for (int t = 0; t < 14; t++) begin
         logic [7:0]  opc;
         logic [23:0] adr;
         int          sel_op;
         sel_op = int'($urandom_range(0, 2));
         opc    = (sel_op == 0) ? 8'h03 : (sel_op == 1) ? 8'h0B : 8'h3B;
         adr    = 24'($urandom);
         if ($urandom_range(0, 3) == 0) adr[20:0] = 21'h1FFFFF - 21'($urandom_range(0, 3));
         mode3  = 1'($urandom_range(0, 1));
         do_read(opc, adr, int'($urandom_range(1, 5)), "R3 R4 R5 R6 random");
      end

      done = 1'b1;
      report();
   end

endmodule